// File: doc/BRIEF.md
# Layer-Sequenced Neuron Evaluation Engine

This block runs a forward pass through a small fully connected perceptron stored in on-chip weight storage. It evaluates one neuron per clock: each registered input lane is multiplied by that neuron's weight row in the same cycle, a bias weight is added, and the result is summed, rounded and saturated. Sums from hidden layers pass through a bounded squash; sums from the last layer leave as they are. Every result streams out with a valid flag and tags for its layer and node.

Storage treats every layer as `LANES` nodes wide, each with `LANES` input weights and one bias weight. Weights a narrower layer does not use are written as zero. A per-layer node count makes the sequencer skip the unused rows. When a layer's last result has left the pipeline, the layer's outputs replace the input bank. Lanes at or above that layer's node count are cleared. The next layer then starts. A start pulse begins a pass, and a done pulse closes it.

Data and weights are 16-bit signed fixed point with 8 fractional bits. With the default parameters there are 8 lanes and up to 4 layers.

Top module: `neuron_engine`

## Requirements
- R1: After reset `busy`, `done` and `outValid` are low. A `start` seen while idle loads `inVec` (lane k at bits 16k+15:16k) and raises `busy`. A `start` seen while busy is ignored, and so is any change of `inVec` during the pass.
- R2: A neuron's raw sum is bias·256 plus the sum of input·weight over all lanes, in full precision. It is rounded by adding 128 and shifting right 8 places arithmetically, then saturated to [-32768, 32767].
- R3: In a hidden layer the emitted value is clamp(floor(r/4) + 128, 0, 256), where r is the rounded word. This is a hard sigmoid in Q8.
- R4: Within a layer, nodes come out on consecutive cycles, in increasing node order starting at 0.
- R5: A layer emits exactly as many outputs as its programmed node count (1 to LANES). The count for layer L is written with `cfgWrEn`, `cfgLayer`=L and `cfgNodes`, and resets to LANES.
- R6: Layer L+1 reads layer L's outputs as its inputs. Lanes at or above layer L's node count read as zero, whatever their weights.
- R7: Across a layer boundary the pipeline drains. The first output of the next layer comes exactly 4 cycles after the last output of the previous one.
- R8: `done` is high for a single cycle, the cycle after the last output-layer result. `busy` is low in that cycle. No output is emitted while `busy` is low.
- R9: The first output comes 4 cycles after the cycle in which an accepted `start` is high.
- R10: A weight write stores `wData` at (`wLayer`, `wNode`, `wLane`). Lane index LANES selects the bias weight.
- R11: `numLayers` (1 to MAX_LAYERS) is sampled at start. Layer `numLayers`-1 is the output layer and has `outHidden` low. All earlier layers have `outHidden` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wWe | input | 1 | Weight write enable |
| wLayer | input | $clog2(MAX_LAYERS) | Weight write layer |
| wNode | input | $clog2(LANES) | Weight write node |
| wLane | input | $clog2(LANES+1) | Weight write lane; LANES selects the bias |
| wData | input | 16 | Weight value, Q8 signed |
| cfgWrEn | input | 1 | Node count write enable |
| cfgLayer | input | $clog2(MAX_LAYERS) | Layer whose node count is written |
| cfgNodes | input | $clog2(LANES+1) | Node count, 1 to LANES |
| numLayers | input | $clog2(MAX_LAYERS+1) | Layers in a pass, sampled at start |
| start | input | 1 | Begin a pass |
| inVec | input | LANES*16 | Input vector, lane k at bits 16k+15:16k |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| outValid | output | 1 | Result valid |
| outData | output | 16 | Result, Q8 signed |
| outLayer | output | $clog2(MAX_LAYERS) | Layer of the result |
| outNode | output | $clog2(LANES) | Node of the result |
| outHidden | output | 1 | Result was squashed |

## Verification
The bench targets the rounding boundaries at exactly half an LSB of either sign. A design that truncates, or that rounds symmetrically, gives results off by one there. Saturation is driven in both directions with full-scale weights: a design that wraps instead of clamping produces values of the wrong sign. A narrow layer followed by a layer with large weights on its unused lanes exposes a bank swap that leaves stale values behind, because those weights would then change the results. Draining, the first-result latency and the done timing are all measured in cycles. A second start during a pass checks that the running results are not disturbed.

// File: rtl/neuron_pkg.sv
package neuron_pkg;
  localparam int DATA_W = 16;
  localparam int FRAC_W = 8;
  localparam int TAG_W = 8;
  // registers between issue and the output port
  localparam int PIPE_DEPTH = 3;

  typedef logic signed [DATA_W-1:0] word_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic load;              // capture inVec into the input bank
    logic issue;             // evaluate (layer, node) this cycle
    logic hidden;            // current layer is not the output layer
    logic swap;              // copy layer results into the input bank
    logic [TAG_W-1:0] layer;
    logic [TAG_W-1:0] node;
    logic [TAG_W-1:0] keep;  // node count of the current layer
  } strobe_t;
endpackage

// File: rtl/neuron_ctl.sv
module neuron_ctl
  import neuron_pkg::*;
#(
  parameter int LANES = 8,
  parameter int MAX_LAYERS = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic [$clog2(MAX_LAYERS+1)-1:0] numLayers,
  input  logic cfgWrEn,
  input  logic [$clog2(MAX_LAYERS)-1:0] cfgLayer,
  input  logic [$clog2(LANES+1)-1:0] cfgNodes,
  output strobe_t strb,
  output logic busy,
  output logic done
);
  localparam int LAYER_W = $clog2(MAX_LAYERS);
  localparam int NODE_W = $clog2(LANES);
  localparam int CNT_W = $clog2(LANES+1);
  localparam logic [1:0] DRAIN_END = 2'(PIPE_DEPTH - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} state_t;

  state_t state;
  logic [LAYER_W-1:0] layer, lastLayer;
  logic [NODE_W-1:0] node;
  logic [1:0] drainCnt;
  logic [CNT_W-1:0] nodeCnt [MAX_LAYERS];
  logic [CNT_W-1:0] curCnt;
  logic go, lastNode, atLastLayer, drainEnd;

  assign curCnt = nodeCnt[layer];
  assign go = start && (state == ST_IDLE);
  assign lastNode = (CNT_W'(node) + CNT_W'(1)) == curCnt;
  assign atLastLayer = (layer == lastLayer);
  assign drainEnd = (state == ST_DRAIN) && (drainCnt == DRAIN_END);
  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MAX_LAYERS; i++) nodeCnt[i] <= CNT_W'(LANES);
    end else if (cfgWrEn) begin
      nodeCnt[cfgLayer] <= cfgNodes;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      layer <= '0;
      lastLayer <= '0;
      node <= '0;
      drainCnt <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (go) begin
            state <= ST_RUN;
            layer <= '0;
            node <= '0;
            lastLayer <= LAYER_W'(numLayers - 1'b1);
          end
        end
        ST_RUN: begin
          if (lastNode) begin
            state <= ST_DRAIN;
            drainCnt <= '0;
          end else begin
            node <= node + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (drainEnd) begin
            if (atLastLayer) begin
              state <= ST_IDLE;
              done <= 1'b1;
            end else begin
              state <= ST_RUN;
              layer <= layer + 1'b1;
              node <= '0;
            end
          end else begin
            drainCnt <= drainCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load = go;
    strb.issue = (state == ST_RUN);
    strb.hidden = !atLastLayer;
    strb.swap = drainEnd && !atLastLayer;
    strb.layer = TAG_W'(layer);
    strb.node = TAG_W'(node);
    strb.keep = TAG_W'(curCnt);
  end
endmodule

// File: rtl/neuron_dp.sv
module neuron_dp
  import neuron_pkg::*;
#(
  parameter int LANES = 8,
  parameter int MAX_LAYERS = 4
) (
  input  logic clk,
  input  logic rstN,
  input  strobe_t strb,
  input  logic [LANES*DATA_W-1:0] inVec,
  input  logic wWe,
  input  logic [$clog2(MAX_LAYERS)-1:0] wLayer,
  input  logic [$clog2(LANES)-1:0] wNode,
  input  logic [$clog2(LANES+1)-1:0] wLane,
  input  logic [DATA_W-1:0] wData,
  output logic outValid,
  output logic [DATA_W-1:0] outData,
  output logic [$clog2(MAX_LAYERS)-1:0] outLayer,
  output logic [$clog2(LANES)-1:0] outNode,
  output logic outHidden
);
  localparam int LAYER_W = $clog2(MAX_LAYERS);
  localparam int NODE_W = $clog2(LANES);
  localparam int LANE_W = $clog2(LANES+1);
  localparam int PROD_W = 2*DATA_W;
  localparam int ACC_W = PROD_W + $clog2(LANES+1) + 1;
  localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1) <<< (FRAC_W-1);
  localparam logic signed [ACC_W-1:0] POS_LIM = (ACC_W'(1) <<< (DATA_W-1)) - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] NEG_LIM = -POS_LIM - ACC_W'(1);
  localparam logic signed [DATA_W:0] SQ_MID = (DATA_W+1)'(1) <<< (FRAC_W-1);
  localparam logic signed [DATA_W:0] SQ_TOP = (DATA_W+1)'(1) <<< FRAC_W;

  word_t wMem [MAX_LAYERS][LANES][LANES+1];
  word_t inReg [LANES];
  word_t nextBuf [LANES];

  logic [LAYER_W-1:0] curLayer;
  logic [NODE_W-1:0] curNode;
  assign curLayer = strb.layer[LAYER_W-1:0];
  assign curNode = strb.node[NODE_W-1:0];

  // weight storage
  always_ff @(posedge clk) begin
    if (wWe && (wLane <= LANE_W'(LANES))) wMem[wLayer][wNode][wLane] <= word_t'(wData);
  end

  // stage 1: all products of one neuron in parallel
  logic signed [PROD_W-1:0] prod [LANES];
  logic signed [ACC_W-1:0] bias1;
  logic v1, h1;
  logic [LAYER_W-1:0] l1;
  logic [NODE_W-1:0] n1;

  for (genvar i = 0; i < LANES; i++) begin : g_mul
    always_ff @(posedge clk) prod[i] <= inReg[i] * wMem[curLayer][curNode][i];
  end

  always_ff @(posedge clk) begin
    bias1 <= ACC_W'(wMem[curLayer][curNode][LANES]) <<< FRAC_W;
    if (!rstN) v1 <= 1'b0;
    else v1 <= strb.issue;
    h1 <= strb.hidden;
    l1 <= curLayer;
    n1 <= curNode;
  end

  // stage 2: sum, round, saturate
  logic signed [ACC_W-1:0] accSum, accRnd;
  word_t satWord, r2;
  logic v2, h2;
  logic [LAYER_W-1:0] l2;
  logic [NODE_W-1:0] n2;

  always_comb begin
    accSum = bias1;
    for (int i = 0; i < LANES; i++) accSum = accSum + ACC_W'(prod[i]);
    accRnd = (accSum + HALF_LSB) >>> FRAC_W;
    if (accRnd > POS_LIM) satWord = POS_LIM[DATA_W-1:0];
    else if (accRnd < NEG_LIM) satWord = NEG_LIM[DATA_W-1:0];
    else satWord = accRnd[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) v2 <= 1'b0;
    else v2 <= v1;
    r2 <= satWord;
    h2 <= h1;
    l2 <= l1;
    n2 <= n1;
  end

  // stage 3: squash and output register
  logic signed [DATA_W:0] sqRaw;
  word_t sqWord, finalWord;

  always_comb begin
    sqRaw = (DATA_W+1)'(r2 >>> 2) + SQ_MID;
    if (sqRaw < 0) sqWord = '0;
    else if (sqRaw > SQ_TOP) sqWord = SQ_TOP[DATA_W-1:0];
    else sqWord = sqRaw[DATA_W-1:0];
    finalWord = h2 ? sqWord : r2;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData <= '0;
      outLayer <= '0;
      outNode <= '0;
      outHidden <= 1'b0;
    end else begin
      outValid <= v2;
      if (v2) begin
        outData <= finalWord;
        outLayer <= l2;
        outNode <= n2;
        outHidden <= h2;
      end
    end
  end

  // result bank and input bank
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LANES; i++) begin
        inReg[i] <= '0;
        nextBuf[i] <= '0;
      end
    end else begin
      if (v2) nextBuf[n2] <= finalWord;
      for (int i = 0; i < LANES; i++) begin
        if (strb.load) inReg[i] <= word_t'(inVec[i*DATA_W +: DATA_W]);
        else if (strb.swap) inReg[i] <= (i < int'(strb.keep)) ? nextBuf[i] : '0;
      end
    end
  end
endmodule

// File: rtl/neuron_engine.sv
module neuron_engine
  import neuron_pkg::*;
#(
  parameter int LANES = 8,
  parameter int MAX_LAYERS = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic wWe,
  input  logic [$clog2(MAX_LAYERS)-1:0] wLayer,
  input  logic [$clog2(LANES)-1:0] wNode,
  input  logic [$clog2(LANES+1)-1:0] wLane,
  input  logic [15:0] wData,
  input  logic cfgWrEn,
  input  logic [$clog2(MAX_LAYERS)-1:0] cfgLayer,
  input  logic [$clog2(LANES+1)-1:0] cfgNodes,
  input  logic [$clog2(MAX_LAYERS+1)-1:0] numLayers,
  input  logic start,
  input  logic [LANES*16-1:0] inVec,
  output logic busy,
  output logic done,
  output logic outValid,
  output logic [15:0] outData,
  output logic [$clog2(MAX_LAYERS)-1:0] outLayer,
  output logic [$clog2(LANES)-1:0] outNode,
  output logic outHidden
);
  strobe_t strb;

  neuron_ctl #(.LANES(LANES), .MAX_LAYERS(MAX_LAYERS)) u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .numLayers(numLayers),
    .cfgWrEn(cfgWrEn), .cfgLayer(cfgLayer), .cfgNodes(cfgNodes),
    .strb(strb), .busy(busy), .done(done)
  );

  neuron_dp #(.LANES(LANES), .MAX_LAYERS(MAX_LAYERS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inVec(inVec),
    .wWe(wWe), .wLayer(wLayer), .wNode(wNode), .wLane(wLane), .wData(wData),
    .outValid(outValid), .outData(outData), .outLayer(outLayer),
    .outNode(outNode), .outHidden(outHidden)
  );
endmodule

// File: rtl/neuron_chk.sv
module neuron_chk #(
  parameter int LANES = 8,
  parameter int MAX_LAYERS = 4
) (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic outValid,
  input logic [15:0] outData,
  input logic [$clog2(MAX_LAYERS)-1:0] outLayer,
  input logic [$clog2(LANES)-1:0] outNode,
  input logic outHidden
);
  localparam int NODE_W = $clog2(LANES);

  assert_out_in_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> busy);

  assert_done_after_out_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(outValid) && !busy));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_squash_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outHidden) |-> ($signed(outData) >= 0 && $signed(outData) <= 256));

  assert_node_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(outValid)) |-> (outNode - $past(outNode)) == NODE_W'(1));

  assert_layer_drain_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(outValid)) |-> outLayer == $past(outLayer));
endmodule

bind neuron_engine neuron_chk #(.LANES(LANES), .MAX_LAYERS(MAX_LAYERS)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .outValid(outValid),
  .outData(outData), .outLayer(outLayer), .outNode(outNode), .outHidden(outHidden)
);

// File: tb/neuron_engine_tb.sv
`timescale 1ns/1ps
module neuron_engine_tb;
  localparam int LANES = 8;
  localparam int MAX_LAYERS = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wWe = 1'b0;
  logic [1:0] wLayer = '0;
  logic [2:0] wNode = '0;
  logic [3:0] wLane = '0;
  logic [15:0] wData = '0;
  logic cfgWrEn = 1'b0;
  logic [1:0] cfgLayer = '0;
  logic [3:0] cfgNodes = '0;
  logic [2:0] numLayers = '0;
  logic start = 1'b0;
  logic [LANES*16-1:0] inVec = '0;
  logic busy, done, outValid, outHidden;
  logic [15:0] outData;
  logic [1:0] outLayer;
  logic [2:0] outNode;

  neuron_engine #(.LANES(LANES), .MAX_LAYERS(MAX_LAYERS)) u_dut (
    .clk(clk), .rstN(rstN), .wWe(wWe), .wLayer(wLayer), .wNode(wNode),
    .wLane(wLane), .wData(wData), .cfgWrEn(cfgWrEn), .cfgLayer(cfgLayer),
    .cfgNodes(cfgNodes), .numLayers(numLayers), .start(start), .inVec(inVec),
    .busy(busy), .done(done), .outValid(outValid), .outData(outData),
    .outLayer(outLayer), .outNode(outNode), .outHidden(outHidden)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;
  string testName = "";

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", req, testName, act, exp);
    end
  endtask

  typedef struct { int layer; int node; int data; } exp_t;
  exp_t expQ[$];

  int wM [MAX_LAYERS][LANES][LANES+1];
  int cntM [MAX_LAYERS];
  int unsigned seed = 32'h1234_5678;

  function automatic int rnd(int lo, int hi);
    seed = seed * 1103515245 + 12345;
    return lo + int'((seed >> 8) % unsigned'(hi - lo + 1));
  endfunction

  function automatic int roundSat(longint s);
    longint t;
    t = (s + 128) >>> 8;
    if (t > 32767) t = 32767;
    if (t < -32768) t = -32768;
    return int'(t);
  endfunction

  function automatic int squash(int r);
    int t;
    t = (r >>> 2) + 128;
    if (t < 0) t = 0;
    if (t > 256) t = 256;
    return t;
  endfunction

  task automatic putW(input int l, input int n, input int k, input int v);
    wM[l][n][k] = v;
    @(negedge clk);
    wWe = 1'b1; wLayer = 2'(l); wNode = 3'(n); wLane = 4'(k); wData = 16'(v);
    @(negedge clk);
    wWe = 1'b0;
  endtask

  task automatic setCnt(input int l, input int c);
    cntM[l] = c;
    @(negedge clk);
    cfgWrEn = 1'b1; cfgLayer = 2'(l); cfgNodes = 4'(c);
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic clearAll();
    for (int l = 0; l < MAX_LAYERS; l++)
      for (int n = 0; n < LANES; n++)
        for (int k = 0; k <= LANES; k++) putW(l, n, k, 0);
  endtask

  task automatic fillRandom(input int nl, input int lo, input int hi);
    for (int l = 0; l < nl; l++)
      for (int n = 0; n < cntM[l]; n++)
        for (int k = 0; k <= LANES; k++) putW(l, n, k, rnd(lo, hi));
  endtask

  // monitor state
  int startCyc = 0;
  int lastCyc = 0;
  int lastLayer = 0;
  int curNl = 1;
  bit waitFirst = 1'b0;
  exp_t mon;

  // driver: model the pass, queue expectations, pulse start, wait for done
  task automatic runEval(input int nl, input int vin[LANES], input bit intrude);
    int cur[LANES];
    int nxt[LANES];
    longint s;
    int r;
    exp_t e;
    for (int k = 0; k < LANES; k++) cur[k] = vin[k];
    for (int l = 0; l < nl; l++) begin
      for (int n = 0; n < LANES; n++) nxt[n] = 0;
      for (int n = 0; n < cntM[l]; n++) begin
        s = longint'(wM[l][n][LANES]) * 256;
        for (int k = 0; k < LANES; k++) s += longint'(cur[k]) * longint'(wM[l][n][k]);
        r = roundSat(s);
        if (l < nl - 1) r = squash(r);
        nxt[n] = r;
        e.layer = l; e.node = n; e.data = r;
        expQ.push_back(e);
      end
      for (int k = 0; k < LANES; k++) cur[k] = nxt[k];
    end
    @(negedge clk);
    numLayers = 3'(nl);
    for (int k = 0; k < LANES; k++) inVec[k*16 +: 16] = 16'(vin[k]);
    start = 1'b1;
    startCyc = cyc;
    curNl = nl;
    waitFirst = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R1 busy after start", busy, 1);
    if (intrude) begin
      @(negedge clk);
      inVec = ~inVec;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      inVec = '0;
    end
    do @(negedge clk); while (!done);
    repeat (2) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R5 extra output", outNode, -1);
        end else begin
          mon = expQ.pop_front();
          check(int'(outLayer) == mon.layer && int'(outNode) == mon.node,
                "R5 layer/node order", outLayer * 100 + outNode, mon.layer * 100 + mon.node);
          check(int'($signed(outData)) == mon.data,
                (mon.layer == curNl - 1) ? "R2 output value" : "R3 hidden value",
                $signed(outData), mon.data);
          check(outHidden == (mon.layer != curNl - 1), "R11 hidden flag",
                outHidden, mon.layer != curNl - 1);
          if (waitFirst) begin
            check(cyc - startCyc == 4, "R9 first result latency", cyc - startCyc, 4);
            waitFirst = 1'b0;
          end else if (int'(outLayer) != lastLayer) begin
            check(cyc - lastCyc == 4, "R7 layer drain gap", cyc - lastCyc, 4);
          end else begin
            check(cyc - lastCyc == 1, "R4 back-to-back nodes", cyc - lastCyc, 1);
          end
          lastCyc = cyc;
          lastLayer = int'(outLayer);
        end
      end
      if (done) begin
        check(cyc - lastCyc == 1, "R8 done timing", cyc - lastCyc, 1);
        check(!busy, "R8 busy low at done", busy, 0);
        check(expQ.size() == 0, "R5 missing outputs", expQ.size(), 0);
        check(lastLayer == curNl - 1, "R11 last layer", lastLayer, curNl - 1);
      end
    end
  end

  initial begin
    #(8 * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int vin[LANES];
    testName = "reset";
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 reset busy", busy, 0);
    check(done == 1'b0, "R1 reset done", done, 0);
    check(outValid == 1'b0, "R1 reset valid", outValid, 0);
    rstN = 1'b1;
    for (int l = 0; l < MAX_LAYERS; l++) cntM[l] = LANES;

    // T1: rounding at half an LSB and bias lane (R2, R10)
    testName = "T1 rounding R10 bias lane";
    clearAll();
    setCnt(0, 4);
    putW(0, 0, 0, 128);
    putW(0, 1, 0, -128);
    putW(0, 2, 0, 384);
    putW(0, 2, LANES, -1);
    putW(0, 3, LANES, 256);
    for (int k = 0; k < LANES; k++) vin[k] = 5;
    vin[0] = 1;
    runEval(1, vin, 1'b0);

    // T2: saturation both ways (R2)
    testName = "T2 saturation";
    setCnt(0, 2);
    for (int k = 0; k < LANES; k++) begin
      putW(0, 0, k, 32767);
      putW(0, 1, k, -32768);
      vin[k] = 32767;
    end
    runEval(1, vin, 1'b0);

    // T3: three layers, start during pass ignored (R1)
    testName = "T3 R1 start ignored";
    clearAll();
    setCnt(0, 5); setCnt(1, 8); setCnt(2, 3);
    fillRandom(3, -300, 300);
    for (int k = 0; k < LANES; k++) vin[k] = rnd(-1000, 1000);
    runEval(3, vin, 1'b1);

    // T4: narrow layer, large weights on unused lanes of next (R6)
    testName = "T4 R6 cleared lanes";
    clearAll();
    setCnt(0, 3); setCnt(1, 4);
    fillRandom(2, -200, 200);
    for (int n = 0; n < 4; n++)
      for (int k = 3; k < LANES; k++) putW(1, n, k, 20000);
    for (int k = 0; k < LANES; k++) vin[k] = rnd(-800, 800);
    runEval(2, vin, 1'b0);

    // T5: four layers incl. a single-node layer (R5, R11)
    testName = "T5 four layers";
    clearAll();
    setCnt(0, 8); setCnt(1, 1); setCnt(2, 6); setCnt(3, 2);
    fillRandom(4, -300, 300);
    for (int k = 0; k < LANES; k++) vin[k] = rnd(-1000, 1000);
    runEval(4, vin, 1'b0);

    // T6: big weights to reach both squash clamps (R3)
    testName = "T6 squash clamps";
    clearAll();
    setCnt(0, 8); setCnt(1, 8);
    fillRandom(2, -2000, 2000);
    for (int k = 0; k < LANES; k++) vin[k] = rnd(-2000, 2000);
    runEval(2, vin, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule